// File: doc/BRIEF.md
# Serial Gigabit Link Recovery Sequencer

This block brings a serial gigabit link to an external PHY back up after the link state or the speed has changed. Some silicon can lose that link at such a change. The recovery is to put every clock domain of the serial interface back into reset and then bring them out of reset one at a time, in a fixed order. After that the block restarts autonegotiation until the link debug status reports a good state. The number of attempts is capped.

A one-cycle `trig_i` starts a run only when `fix_en_i` is also high. `fix_en_i` is tied per instance. It must stay low when the serial link goes to a switch instead of a PHY, because a run there breaks connectivity.

All waits come from one cycle timer. It is scaled by `CYC_PER_US` and by the `*_US` parameters, so a bench can shrink the 10 µs, 100 µs and 10 ms intervals.

Top module: `sgmii_recovery_seq`

## Requirements
- R1: A run starts only on a clock edge where both `trig_i` and `fix_en_i` are high while idle. A `trig_i` seen while `fix_en_i` is low, or while a run is active (`busy_o` high), changes nothing.
- R2: The edge after the start samples `an_able_i`. If it is low, `done_o` pulses in the next cycle with `ok_o` and `exhausted_o` low, and `rst_n_o`, `an_phy_rst_o` and `an_ena_o` keep the values they had before the start.
- R3: If `an_able_i` is high, `rst_n_o` is driven to all zeros and held there for SETTLE_US microseconds.
- R4: The domains are released by setting their active-low bits one at a time, each followed by a SETTLE_US wait. The order is bit 4, bit 2, bit 3, bit 0, bit 1. Bit 4 rises SETTLE_US after the all-zero step, and each later bit rises one SETTLE_US after the previous one.
- R5: Each attempt sets `an_phy_rst_o` and `an_ena_o` together. `an_phy_rst_o` stays high for AN_RESET_US, then falls while `an_ena_o` stays high. `an_phy_rst_o` is high only after all five reset bits are released.
- R6: AN_WAIT_US after `an_phy_rst_o` falls, the block samples `link_dbg_i`. A value of 4'hF ends the run with `ok_o` high.
- R7: An attempt counter starts at 0. When the counter already equals MAX_TRY at a sample, the run ends with `exhausted_o` high and `ok_o` low, even if that sample is 4'hF. A run therefore makes at most MAX_TRY+1 attempts. `ok_o` and `exhausted_o` are never both high.
- R8: `done_o` is high for exactly one cycle at the end of a run. `ok_o` and `exhausted_o` hold their values until the next start, which clears them. A full run ends `2 + 6·S + k·(A + W)` clock edges after the start edge, where S, A and W are the three waits in cycles and k is the number of attempts.
- R9: A synchronous active-high `rst` gives idle, `rst_n_o` all zeros, both control bits low, and `done_o`, `ok_o`, `exhausted_o` and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Update trigger pulse |
| fix_en_i | input | 1 | Per-instance permission to run the sequence |
| an_able_i | input | 1 | Autonegotiation ability status bit |
| link_dbg_i | input | 4 | Link debug status nibble |
| rst_n_o | output | 5 | Active-low per-domain reset release vector |
| an_phy_rst_o | output | 1 | Autonegotiation PHY reset control bit |
| an_ena_o | output | 1 | Autonegotiation enable control bit |
| busy_o | output | 1 | A run is active |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Last run found a good link |
| exhausted_o | output | 1 | Last run hit the attempt cap |

## Verification
A good-link sample and the attempt cap can both be true at the sample of the final attempt. The bench provokes this by holding the debug nibble at 4'hF only from the eleventh `an_phy_rst_o` rise onward. It then expects `exhausted_o` high and `ok_o` low, with `done_o` at the edge count R8 gives for eleven attempts. A second collision is a trigger pulse injected in the middle of a run. The bench judges it by the run ending at exactly the unperturbed cycle with a single `done_o` pulse.

// File: rtl/srs_pkg.sv
package srs_pkg;

   localparam int SRS_DOMAINS = 5;

   typedef enum logic [2:0] {
      SRS_IDLE,
      SRS_CHECK,
      SRS_HOLD,
      SRS_REL,
      SRS_AN_SET,
      SRS_AN_WAIT,
      SRS_FIN
   } srs_state_e;

   // Release order of the active-low domain bits; the order is behaviour.
   function automatic int unsigned dom_at_step(input int unsigned step);
      case (step)
         0:       return 4;
         1:       return 2;
         2:       return 3;
         3:       return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int unsigned max3(input int unsigned a, b, c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/srs_timer.sv
module srs_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          expire_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

   AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!load_i && cnt_q == '0) |=> cnt_q == '0); // R8
endmodule

// File: rtl/srs_release.sv
module srs_release #(
   parameter int NUM_DOM = 5,
   parameter int SW      = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clear_i,
   input  logic               fire_i,
   input  logic [SW-1:0]      step_i,
   output logic [NUM_DOM-1:0] rst_n_o
);
   if (NUM_DOM != srs_pkg::SRS_DOMAINS) begin : g_bad_dom
      $error("srs_release: NUM_DOM must equal the fixed domain count");
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic sel;
      assign sel = fire_i && (srs_pkg::dom_at_step(32'(step_i)) == d);
      always_ff @(posedge clk) begin
         if (rst || clear_i)
            rst_n_o[d] <= 1'b0;
         else if (sel)
            rst_n_o[d] <= 1'b1;
      end
   end

   AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
      !clear_i |=> $countones(rst_n_o & ~$past(rst_n_o)) <= 1); // R4
endmodule

// File: rtl/srs_retry.sv
module srs_retry #(
   parameter int MAX_TRY = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_cap_o
);
   localparam int CW = (MAX_TRY < 1) ? 1 : $clog2(MAX_TRY + 1);

   if (MAX_TRY < 0) begin : g_bad_cap
      $error("srs_retry: MAX_TRY must not be negative");
   end

   logic [CW-1:0] tries_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i)
         tries_q <= '0;
      else if (inc_i)
         tries_q <= tries_q + 1'b1;
   end

   assign at_cap_o = (32'(tries_q) >= MAX_TRY);

   AST_TRY_CAP: assert property (@(posedge clk) disable iff (rst)
      32'(tries_q) <= MAX_TRY); // R7
endmodule

// File: rtl/sgmii_recovery_seq.sv
module sgmii_recovery_seq #(
   parameter int         CYC_PER_US  = 125,
   parameter int         SETTLE_US   = 10,
   parameter int         AN_RESET_US = 100,
   parameter int         AN_WAIT_US  = 10000,
   parameter int         MAX_TRY     = 10,
   parameter int         NUM_DOM     = 5,
   parameter int         DBG_W       = 4,
   parameter logic [3:0] GOOD_CODE   = 4'hF
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig_i,
   input  logic               fix_en_i,
   input  logic               an_able_i,
   input  logic [DBG_W-1:0]   link_dbg_i,
   output logic [NUM_DOM-1:0] rst_n_o,
   output logic               an_phy_rst_o,
   output logic               an_ena_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               ok_o,
   output logic               exhausted_o
);
   import srs_pkg::*;

   localparam int D_SETTLE = SETTLE_US * CYC_PER_US;
   localparam int D_ANRST  = AN_RESET_US * CYC_PER_US;
   localparam int D_ANWAIT = AN_WAIT_US * CYC_PER_US;
   localparam int D_MAX    = int'(max3(D_SETTLE, D_ANRST, D_ANWAIT));
   localparam int TW       = $clog2(D_MAX + 1);
   localparam int SW       = $clog2(NUM_DOM);
   localparam logic [SW-1:0] LAST_STEP = SW'(NUM_DOM - 1);

   if (CYC_PER_US < 1 || SETTLE_US < 1 || AN_RESET_US < 1 || AN_WAIT_US < 1) begin : g_bad_time
      $error("sgmii_recovery_seq: every interval must be at least one cycle");
   end
   if (DBG_W != 4) begin : g_bad_dbg
      $error("sgmii_recovery_seq: the debug status is a nibble");
   end

   srs_state_e    state_q, state_d;
   logic [SW-1:0] step_q, fire_step;
   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic          vec_clear, vec_fire;
   logic          try_clr, try_inc, at_cap;
   logic          set_an, drop_prst, start, fin_ok, fin_exh;
   logic          link_good;

   assign link_good = (link_dbg_i == GOOD_CODE);

   srs_timer #(.TW(TW)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .load_i    (tmr_load),
      .load_val_i(tmr_val),
      .expire_o  (tmr_exp)
   );

   srs_release #(.NUM_DOM(NUM_DOM), .SW(SW)) u_release (
      .clk    (clk),
      .rst    (rst),
      .clear_i(vec_clear),
      .fire_i (vec_fire),
      .step_i (fire_step),
      .rst_n_o(rst_n_o)
   );

   srs_retry #(.MAX_TRY(MAX_TRY)) u_retry (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (try_clr),
      .inc_i   (try_inc),
      .at_cap_o(at_cap)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      vec_clear = 1'b0;
      vec_fire  = 1'b0;
      fire_step = step_q;
      try_clr   = 1'b0;
      try_inc   = 1'b0;
      set_an    = 1'b0;
      drop_prst = 1'b0;
      start     = 1'b0;
      fin_ok    = 1'b0;
      fin_exh   = 1'b0;
      unique case (state_q)
         SRS_IDLE: begin
            if (trig_i && fix_en_i) begin
               state_d = SRS_CHECK;
               start   = 1'b1;
            end
         end
         SRS_CHECK: begin
            if (!an_able_i) begin
               state_d = SRS_FIN;
            end else begin
               state_d   = SRS_HOLD;
               vec_clear = 1'b1;
               try_clr   = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = TW'(D_SETTLE - 1);
            end
         end
         SRS_HOLD: begin
            if (tmr_exp) begin
               state_d   = SRS_REL;
               vec_fire  = 1'b1;
               fire_step = '0;
               tmr_load  = 1'b1;
               tmr_val   = TW'(D_SETTLE - 1);
            end
         end
         SRS_REL: begin
            if (tmr_exp) begin
               if (step_q == LAST_STEP) begin
                  state_d  = SRS_AN_SET;
                  set_an   = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(D_ANRST - 1);
               end else begin
                  vec_fire  = 1'b1;
                  fire_step = step_q + 1'b1;
                  tmr_load  = 1'b1;
                  tmr_val   = TW'(D_SETTLE - 1);
               end
            end
         end
         SRS_AN_SET: begin
            if (tmr_exp) begin
               state_d   = SRS_AN_WAIT;
               drop_prst = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = TW'(D_ANWAIT - 1);
            end
         end
         SRS_AN_WAIT: begin
            if (tmr_exp) begin
               if (at_cap) begin
                  state_d = SRS_FIN;
                  fin_exh = 1'b1;
               end else if (link_good) begin
                  state_d = SRS_FIN;
                  fin_ok  = 1'b1;
               end else begin
                  state_d  = SRS_AN_SET;
                  try_inc  = 1'b1;
                  set_an   = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(D_ANRST - 1);
               end
            end
         end
         SRS_FIN: state_d = SRS_IDLE;
         default: state_d = SRS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= SRS_IDLE;
         step_q       <= '0;
         an_phy_rst_o <= 1'b0;
         an_ena_o     <= 1'b0;
         ok_o         <= 1'b0;
         exhausted_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (vec_fire)
            step_q <= fire_step;
         if (set_an) begin
            an_phy_rst_o <= 1'b1;
            an_ena_o     <= 1'b1;
         end else if (drop_prst) begin
            an_phy_rst_o <= 1'b0;
         end
         if (start) begin
            ok_o        <= 1'b0;
            exhausted_o <= 1'b0;
         end else if (fin_ok) begin
            ok_o <= 1'b1;
         end else if (fin_exh) begin
            exhausted_o <= 1'b1;
         end
      end
   end

   assign busy_o = (state_q != SRS_IDLE);
   assign done_o = (state_q == SRS_FIN);

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> $past(trig_i && fix_en_i)); // R1
   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (state_q == SRS_HOLD) |-> (rst_n_o == '0)); // R3
   AST_REL_ORDER: assert property (@(posedge clk) disable iff (rst)
      (!rst_n_o[2] || rst_n_o[4]) && (!rst_n_o[3] || rst_n_o[2]) &&
      (!rst_n_o[0] || rst_n_o[3]) && (!rst_n_o[1] || rst_n_o[0])); // R4
   AST_PRST_WITH_ENA: assert property (@(posedge clk) disable iff (rst)
      an_phy_rst_o |-> an_ena_o); // R5
   AST_PRST_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
      an_phy_rst_o |-> (&rst_n_o)); // R5
   AST_OK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
      $rose(ok_o) |-> ($past(link_dbg_i) == GOOD_CODE)); // R6
   AST_OK_EXH_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(ok_o && exhausted_o)); // R7
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o); // R8
endmodule

// File: tb/sgmii_recovery_seq_bench.sv
module sgmii_recovery_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CPU   = 2;
   localparam int S_CYC = 10 * CPU;
   localparam int A_CYC = 100 * CPU;
   localparam int W_CYC = 50 * CPU;
   localparam int ORD [5] = '{4, 2, 3, 0, 1};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trig = 1'b0;
   logic       en = 1'b0;
   logic       able = 1'b1;
   logic [3:0] dbg = 4'h7;
   logic [4:0] rst_n;
   logic       prst, ena, busy, done, ok, exh;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sgmii_recovery_seq #(.CYC_PER_US(CPU), .AN_WAIT_US(50)) u_sgmii_recovery_seq (
      .clk(clk), .rst(rst), .trig_i(trig), .fix_en_i(en), .an_able_i(able),
      .link_dbg_i(dbg), .rst_n_o(rst_n), .an_phy_rst_o(prst), .an_ena_o(ena),
      .busy_o(busy), .done_o(done), .ok_o(ok), .exhausted_o(exh)
   );

   task automatic chk(input bit cond, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic test_reset();
      chk(rst_n == 5'd0, "R9", "reset vector", int'(rst_n), 0);
      chk(!prst && !ena, "R9", "control bits", int'({prst, ena}), 0);
      chk(!busy && !done && !ok && !exh, "R9", "status", int'({busy, done, ok, exh}), 0);
   endtask

   task automatic test_no_enable();
      logic [4:0] v0 = rst_n;
      int bad = 0;
      en = 1'b0; trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (busy || done || rst_n != v0) bad++;
      end
      chk(bad == 0, "R1", "trigger without enable acted", bad, 0);
      en = 1'b1;
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk(!busy && rst_n == v0, "R1", "enable without trigger acted", int'(busy), 0);
   endtask

   task automatic run_seq(input int good_after, input bit ab, input int exp_k,
                          input bit exp_ok, input bit exp_exh, input bit poke,
                          input string req);
      int cnt = 0, att = 0, phy_hi = 0, dones = 0;
      int rise [5];
      bit seen = 0, zero_bad = 0, prev_p = 0;
      logic [4:0] prev = rst_n;
      logic [4:0] v0 = rst_n;
      logic e0 = ena;
      int exp_end;
      for (int i = 0; i < 5; i++) rise[i] = -1;
      able = ab; dbg = 4'h7; en = 1'b1; trig = 1'b1;
      while (!seen && cnt < 8000) begin
         @(posedge clk); cnt++;
         @(negedge clk);
         trig = (poke && cnt == 50);
         for (int i = 0; i < 5; i++)
            if (rst_n[i] && !prev[i]) rise[i] = cnt;
         prev = rst_n;
         if (ab && cnt == 2 + S_CYC / 2 && rst_n != 5'd0) zero_bad = 1;
         if (prst && !prev_p) att++;
         if (prst) phy_hi++;
         prev_p = prst;
         dbg = (good_after != 0 && att >= good_after) ? 4'hF : 4'h7;
         if (done) begin seen = 1; dones++; end
      end
      if (ab) begin
         exp_end = 2 + 6 * S_CYC + exp_k * (A_CYC + W_CYC);
         chk(cnt == exp_end, req, "done edge", cnt, exp_end);
         chk(!zero_bad, "R3", "vector not all zero in hold", int'(zero_bad), 0);
         for (int p = 0; p < 5; p++)
            chk(rise[ORD[p]] == 2 + (p + 1) * S_CYC, "R4", "release edge",
                rise[ORD[p]], 2 + (p + 1) * S_CYC);
         chk(att == exp_k, "R7", "attempts", att, exp_k);
         chk(phy_hi == exp_k * A_CYC, "R5", "phy reset cycles", phy_hi, exp_k * A_CYC);
         chk(ena && !prst, "R5", "ena kept, phy reset dropped", int'({ena, prst}), 2);
         chk(rst_n == 5'h1F, "R4", "final vector", int'(rst_n), 31);
      end else begin
         chk(cnt == 2, "R2", "done edge without ability", cnt, 2);
         chk(rst_n == v0 && ena == e0 && !prst, "R2", "outputs touched",
             int'(rst_n), int'(v0));
      end
      chk(ok == exp_ok, req, "ok", int'(ok), int'(exp_ok));
      chk(exh == exp_exh, req, "exhausted", int'(exh), int'(exp_exh));
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (done) dones++;
      end
      chk(dones == 1, "R8", "done pulse count", dones, 1);
      chk(ok == exp_ok && exh == exp_exh && !busy, "R8", "status held",
          int'({ok, exh}), int'({exp_ok, exp_exh}));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst = 1'b0;
      @(negedge clk);
      test_reset();
      test_no_enable();
      run_seq(1, 1'b1, 1, 1'b1, 1'b0, 1'b0, "R6");
      run_seq(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R2");
      run_seq(3, 1'b1, 3, 1'b1, 1'b0, 1'b1, "R6");
      run_seq(0, 1'b1, 11, 1'b0, 1'b1, 1'b0, "R7");
      run_seq(11, 1'b1, 11, 1'b0, 1'b1, 1'b0, "R7");
      run_seq(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R8");
      test_no_enable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule